// File: doc/BRIEF.md
# Inter-Peer Doorbell Interrupt Register Block

This block is a small register file that a host reaches through a simple 32-bit read/write bus. It holds an interrupt enable mask, a pending-interrupt status word, a read-only identifier giving this node's position among its peers, and a write-only doorbell. Software rings another peer by writing the doorbell. The write becomes an outgoing notification that carries the target peer identifier and a vector number. Notifications from other peers arrive on a separate input and set bits in the local status word. An interrupt line stays high while any set status bit is also enabled in the mask.

Status is cleared by reading it. A handler therefore collects all pending causes with one access and leaves nothing pending behind. If a new notification lands in the same cycle as that read, it is kept, so no event is lost. The peer identifier is a static input that is captured while reset is held. Software cannot change it afterwards.

Top module: `peer_doorbell_regs`

## Requirements
- R1: While `rst` is high, the mask and status registers clear to zero and the position register captures `peer_id_i`. After reset, reads return 0 for mask and status and return the captured identifier for position (0 when `peer_id_i` was 0).
- R2: The register index is taken from `req_addr[ADDR_W-1:2]`; bits 1:0 are ignored. The mask is word 0 (byte offset 0), status is word 1 (offset 4), position is word 2 (offset 8) and doorbell is word 3 (offset 12). The mask is writable in all STAT_W bits, so writing 0xFFFFFFFF reads back 0xFFFFFFFF.
- R3: A write to status ORs the written bits into the status register. After writing 1, the next read returns 1.
- R4: A status read returns the value the register held before the read and then clears the register, so an immediate second read returns 0.
- R5: Writes to the position register do not change it. Later reads still return the captured identifier.
- R6: Reads of the doorbell register and of any offset from 16 up to the top of the window return 0. Writes to those unmapped offsets change no register and produce no notification.
- R7: A doorbell write raises `note_valid` for exactly one cycle, in the cycle after the write is accepted. In that cycle `note_peer` = `req_wdata[31:16]` and `note_vector` = `req_wdata[15:0]`.
- R8: When `in_valid` is high with `in_vector` < STAT_W, status bit `in_vector` is set on the next edge. A vector of STAT_W or above is ignored.
- R9: If an incoming notification and a status read happen in the same cycle, the read returns the old value and the bit set by the notification remains set afterwards.
- R10: `irq` is high exactly when (status & mask) is non-zero. It follows register updates in the cycle after the access.
- R11: Every bus read, mapped or not, produces `rd_valid` high for one cycle in the following cycle, with the read result on `rd_data`. `rd_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| peer_id_i | input | 16 | Static identifier of this peer, captured during reset |
| req_valid | input | 1 | Bus access request, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| in_valid | input | 1 | Incoming notification strobe from another peer |
| in_vector | input | 16 | Vector number of the incoming notification |
| note_valid | output | 1 | One-cycle outgoing notification strobe |
| note_peer | output | 16 | Target peer of the outgoing notification |
| note_vector | output | 16 | Vector of the outgoing notification |
| irq | output | 1 | Interrupt request, high while any enabled status bit is set |

## Verification
Several rules are checked on every cycle by assertions:
- a notification strobe is caused only by a doorbell write;
- read data appears only after a read;
- an incoming vector always lands in status, including when a read collides with it;
- a status read with no incoming event leaves status empty;
- the position value never moves outside reset;
- the interrupt line is never high with an empty mask.

The bench scenarios are needed to show the values that come back over the bus. These are the read-to-clear sequence, the zero result for doorbell and unmapped reads, the exact split of the doorbell word, and that writes to the position register and to unmapped offsets are ignored.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    localparam int DATA_W  = 32;
    localparam int PEER_W  = 16;
    localparam int VEC_W   = 16;
    localparam int NUM_REG = 4;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_STAT = 2'd1,
        SEL_POS  = 2'd2,
        SEL_BELL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
        logic     rd;
        logic     wr;
    } access_t;

    typedef struct packed {
        logic [PEER_W-1:0] peer;
        logic [VEC_W-1:0]  vector;
    } note_t;

    function automatic note_t split_bell(input logic [DATA_W-1:0] word);
        note_t n;
        n.peer   = word[DATA_W-1:VEC_W];
        n.vector = word[VEC_W-1:0];
        return n;
    endfunction

endpackage

// File: rtl/pdb_decode.sv
module pdb_decode
    import pdb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output access_t           acc
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_REG);

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx     = req_addr[ADDR_W-1:2];
        acc.hit = (idx < IDX_LIM);
        acc.sel = reg_sel_e'(idx[1:0]);
        acc.rd  = req_valid & ~req_write;
        acc.wr  = req_valid & req_write;
    end
endmodule

// File: rtl/pdb_status.sv
module pdb_status #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_set_en,
    input  logic [STAT_W-1:0] sw_set_val,
    input  logic              rd_clr,
    input  logic              in_valid,
    input  logic [15:0]       in_vector,
    output logic [STAT_W-1:0] stat_q
);
    localparam int         VB   = $clog2(STAT_W);
    localparam logic [15:0] VLIM = 16'(STAT_W);

    logic [STAT_W-1:0] hw_set;
    logic [STAT_W-1:0] sw_set;

    always_comb begin
        hw_set = '0;
        if (in_valid && (in_vector < VLIM))
            hw_set[in_vector[VB-1:0]] = 1'b1;
        sw_set = sw_set_en ? sw_set_val : '0;
    end

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                stat_q[b] <= 1'b0;
            else
                stat_q[b] <= (stat_q[b] & ~rd_clr) | sw_set[b] | hw_set[b];
        end
    end
endmodule

// File: rtl/pdb_doorbell.sv
module pdb_doorbell
    import pdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] wdata,
    output logic              note_valid,
    output note_t             note
);
    always_ff @(posedge clk) begin
        if (rst) begin
            note_valid <= 1'b0;
            note       <= '0;
        end else begin
            note_valid <= fire;
            if (fire)
                note <= split_bell(wdata);
        end
    end
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
    import pdb_pkg::*;
#(
    parameter int STAT_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       peer_id_i,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              in_valid,
    input  logic [15:0]       in_vector,
    output logic              note_valid,
    output logic [15:0]       note_peer,
    output logic [15:0]       note_vector,
    output logic              irq
);
    access_t           acc;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] stat_q;
    logic [PEER_W-1:0] pos_q;
    logic [DATA_W-1:0] rd_mux;
    note_t             note;
    logic              wr_mask, wr_stat, rd_stat, wr_bell;

    pdb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .acc       (acc)
    );

    always_comb begin
        wr_mask = acc.wr && acc.hit && (acc.sel == SEL_MASK);
        wr_stat = acc.wr && acc.hit && (acc.sel == SEL_STAT);
        rd_stat = acc.rd && acc.hit && (acc.sel == SEL_STAT);
        wr_bell = acc.wr && acc.hit && (acc.sel == SEL_BELL);
    end

    pdb_status #(.STAT_W(STAT_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .sw_set_en  (wr_stat),
        .sw_set_val (req_wdata[STAT_W-1:0]),
        .rd_clr     (rd_stat),
        .in_valid   (in_valid),
        .in_vector  (in_vector),
        .stat_q     (stat_q)
    );

    pdb_doorbell u_bell (
        .clk        (clk),
        .rst        (rst),
        .fire       (wr_bell),
        .wdata      (req_wdata),
        .note_valid (note_valid),
        .note       (note)
    );

    assign note_peer   = note.peer;
    assign note_vector = note.vector;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= req_wdata[STAT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= peer_id_i;
    end

    always_comb begin
        rd_mux = '0;
        if (acc.hit) begin
            case (acc.sel)
                SEL_MASK: rd_mux = DATA_W'(mask_q);
                SEL_STAT: rd_mux = DATA_W'(stat_q);
                SEL_POS:  rd_mux = DATA_W'(pos_q);
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc.rd;
            if (acc.rd)
                rd_data <= rd_mux;
        end
    end

    assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/pdb_checker.sv
module pdb_checker #(
    parameter int STAT_W = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rd_valid,
    input logic              in_valid,
    input logic [15:0]       in_vector,
    input logic              note_valid,
    input logic              irq,
    input logic [STAT_W-1:0] mask_q,
    input logic [STAT_W-1:0] stat_q,
    input logic [15:0]       pos_q
);
    localparam int          VB   = $clog2(STAT_W);
    localparam logic [15:0] VLIM = 16'(STAT_W);

    logic bell_wr, stat_rd, mask_wr;
    assign bell_wr = req_valid && req_write  && (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
    assign stat_rd = req_valid && !req_write && (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
    assign mask_wr = req_valid && req_write  && (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(0));

    // R7
    note_cause_chk: assert property (@(posedge clk) disable iff (rst)
        bell_wr |=> note_valid);
    // R7
    note_only_bell_chk: assert property (@(posedge clk) disable iff (rst)
        !bell_wr |=> !note_valid);
    // R11
    rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);
    // R4
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !in_valid) |=> (stat_q == '0));
    // R8 R9
    in_set_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_vector < VLIM)) |=> stat_q[$past(in_vector[VB-1:0])]);
    // R5
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(pos_q));
    // R2
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_q == $past(req_wdata[STAT_W-1:0])));
    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((mask_q != '0) && (stat_q != '0)));
endmodule

bind peer_doorbell_regs pdb_checker #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_peer_doorbell_regs.sv
`timescale 1ns/1ps
module test_peer_doorbell_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] peer_id_i = 16'h0000;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr  = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        in_valid  = 1'b0;
    logic [15:0] in_vector = 16'h0;
    logic        note_valid;
    logic [15:0] note_peer, note_vector;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] mask_m = 0;
    logic [31:0] stat_m = 0;
    logic [15:0] pos_m  = 0;

    always #10 clk = ~clk;

    peer_doorbell_regs i_peer_doorbell_regs (.*);

    function automatic logic [31:0] vec_bit(input logic [15:0] v);
        return (v < 16'd32) ? (32'h1 << v[4:0]) : 32'h0;
    endfunction

    function automatic logic exp_irq(input logic [31:0] s, input logic [31:0] m);
        return |(s & m);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        req_valid = 1; req_write = 0; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 0;
        chk("R11 rd_valid", 32'(rd_valid), 32'd1);
        d = rd_data;
    endtask

    task automatic notify(input logic [15:0] v);
        in_valid = 1; in_vector = v;
        @(posedge clk); @(negedge clk);
        in_valid = 0;
        stat_m |= vec_bit(v);
    endtask

    task automatic do_reset(input logic [15:0] id);
        rst = 1; peer_id_i = id;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        mask_m = 0; stat_m = 0; pos_m = id;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        do_reset(16'h0000);

        // R1 reset state
        bus_rd(8'd0, d); chk("R1 mask", d, 32'h0);
        bus_rd(8'd4, d); chk("R1 status", d, 32'h0);
        bus_rd(8'd8, d); chk("R1 position", d, 32'h0);
        chk("R10 irq after reset", 32'(irq), 32'd0);

        // R2 mask all ones
        bus_wr(8'd0, 32'hFFFF_FFFF); mask_m = 32'hFFFF_FFFF;
        bus_rd(8'd0, d); chk("R2 mask readback", d, 32'hFFFF_FFFF);

        // R3 set status, R10 irq
        bus_wr(8'd4, 32'h1); stat_m = 32'h1;
        chk("R10 irq on set", 32'(irq), 32'd1);
        bus_rd(8'd4, d); chk("R3 status read", d, 32'h1);
        // R4 cleared
        bus_rd(8'd4, d); chk("R4 second read", d, 32'h0);
        stat_m = 0;
        chk("R10 irq after clear", 32'(irq), 32'd0);

        // R5 position write ignored
        bus_wr(8'd8, 32'h1);
        bus_rd(8'd8, d); chk("R5 position unchanged", d, 32'h0);

        // R6 doorbell and unmapped read zero, unmapped write ignored
        bus_rd(8'd12, d); chk("R6 doorbell read", d, 32'h0);
        bus_wr(8'd64, 32'hFFFF_FFFF);
        chk("R6 no note on unmapped write", 32'(note_valid), 32'd0);
        bus_rd(8'd64, d); chk("R6 unmapped read", d, 32'h0);
        bus_rd(8'd0, d); chk("R6 mask untouched", d, 32'hFFFF_FFFF);
        bus_rd(8'd4, d); chk("R6 status untouched", d, 32'h0);

        // R7 doorbell encode
        bus_wr(8'd12, (32'd8 << 16));
        chk("R7 note_valid", 32'(note_valid), 32'd1);
        chk("R7 peer", 32'(note_peer), 32'd8);
        chk("R7 vector0", 32'(note_vector), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R7 one-cycle pulse", 32'(note_valid), 32'd0);
        bus_wr(8'd12, (32'h0005 << 16) | 32'd1);
        chk("R7 peer5", 32'(note_peer), 32'd5);
        chk("R7 vector1", 32'(note_vector), 32'd1);

        // R8 incoming sets bit, out-of-range ignored
        notify(16'd3);
        bus_rd(8'd4, d); chk("R8 incoming bit3", d, 32'h8); stat_m = 0;
        notify(16'd40);
        bus_rd(8'd4, d); chk("R8 out of range ignored", d, 32'h0); stat_m = 0;

        // R9 read and incoming in same cycle
        notify(16'd0);
        req_valid = 1; req_write = 0; req_addr = 8'd4;
        in_valid = 1; in_vector = 16'd3;
        @(posedge clk); @(negedge clk);
        req_valid = 0; in_valid = 0;
        chk("R9 read returns old", rd_data, 32'h1);
        bus_rd(8'd4, d); chk("R9 set wins", d, 32'h8);
        stat_m = 0;

        // R10 masked status gives no irq
        bus_wr(8'd0, 32'h0000_0002); mask_m = 32'h2;
        notify(16'd0);
        chk("R10 masked no irq", 32'(irq), 32'd0);
        notify(16'd1);
        chk("R10 unmasked irq", 32'(irq), 32'd1);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [31:0] r;
            op = $urandom_range(0, 6);
            r  = $urandom();
            case (op)
                0: begin bus_wr(8'd0, r); mask_m = r; end
                1: begin r = r & 32'h0000_0F0F; bus_wr(8'd4, r); stat_m |= r; end
                2: begin bus_rd(8'd4, d); chk("R4 random status read", d, stat_m); stat_m = 0; end
                3: begin bus_rd(8'd0, d); chk("R2 random mask read", d, mask_m); end
                4: notify(16'(r[5:0]));
                5: begin
                    bus_wr(8'd12, r);
                    chk("R7 random peer", 32'(note_peer), 32'(r[31:16]));
                    chk("R7 random vector", 32'(note_vector), 32'(r[15:0]));
                end
                default: begin
                    bus_rd(8'(16 + 4 * $urandom_range(0, 59)), d);
                    chk("R6 random unmapped", d, 32'h0);
                end
            endcase
            chk("R10 random irq", 32'(irq), 32'(exp_irq(stat_m, mask_m)));
        end

        // R1 position captured from identifier input
        do_reset(16'h00A5);
        bus_rd(8'd8, d); chk("R1 position id", d, 32'h0000_00A5);
        bus_rd(8'd0, d); chk("R1 mask after second reset", d, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule